// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the three clocks of a serial audio port: a root (oversampling) clock, a bit clock and a left/right frame clock. All of them are generated inside one system clock domain. The source is picked from two tick strobes: a peripheral-bus tick or a dedicated audio tick. An optional prescaler divides it. Each prescaled tick is one half-period of the root clock. The bit clock and the frame clock are then derived from two ratios, each a multiple of the frame rate. The root ratio is one of 256, 384, 512 or 768. The bit ratio is one of 16, 24, 32 or 48. The root clock can instead be taken in from a pin, through a tick strobe per incoming half-period. In that case the root output is turned off and the incoming ticks time the bit and frame clocks.

In slave mode the bit and frame clocks come from outside. The block turns off its clock outputs and only reports which channel the incoming frame clock shows. It samples that on each rising edge of the incoming bit clock. Software writes two configuration words into shadow registers. A central state machine copies the shadow into the active set at a frame boundary, so a running frame is never cut short.

The state machine has four states. ST_IDLE is held only in reset. ST_MASTER generates the clocks. ST_SLAVE tracks the external frame clock. ST_HALT holds the clocks low because the ratio pair is illegal. A "load" happens on every cycle in ST_IDLE, ST_SLAVE and ST_HALT, and in ST_MASTER only on the cycle that ends a frame. Each load picks the next state from the shadow. It goes to ST_SLAVE if the slave bit is set, to ST_HALT if the root ratio is not an integer multiple of the bit ratio, and to ST_MASTER otherwise.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted all outputs are 0. Both configuration words reset to 0, which selects the bus tick, master, root clock driven out, ratios 256 and 16, and prescaler off. One cycle after reset is released the block is in ST_MASTER with all clock outputs still 0.
- R2: Prescaler word (address 1): bit 0 enables the prescaler and bits 15:8 hold the value D. With the prescaler enabled, one root half-period lasts D+1 selected source ticks. With it disabled, every source tick is a root half-period.
- R3: Mode word (address 0) bit 0 selects the source: 0 means bus_tick_i and 1 means aud_tick_i. The tick that is not selected has no effect on any output.
- R4: In ST_MASTER, mclk_o toggles on every root half-period. bclk_o toggles once per (root ratio / bit ratio) root half-periods, and every bclk_o edge lines up with an mclk_o edge.
- R5: lrclk_o toggles after every (bit ratio) bclk_o toggles, which is bit ratio / 2 bit clocks. It only changes in the cycle where bclk_o falls.
- R6: Mode word bits 4:3 select the root ratio (0:256, 1:384, 2:512, 3:768). Bits 6:5 select the bit ratio (0:16, 1:24, 2:32, 3:48).
- R7: A ratio pair whose quotient is not an integer (256 or 512 with 24 or 48) puts the block in ST_HALT. There mclk_o, bclk_o and lrclk_o are held 0 while port_oe_o stays 1.
- R8: While running in ST_MASTER, a configuration write does not change the clocks until the current frame ends, with all three clocks low again. The new settings apply from the next cycle.
- R9: Mode word bit 1 selects slave mode (ST_SLAVE). port_oe_o, mclk_oe_o and all clock outputs are 0. chan_o takes the value of lrclk_i sampled at each rising edge of bclk_i, registered once.
- R10: Mode word bit 2 takes the root clock in. mclk_oe_o and mclk_o are 0, and root_in_tick_i replaces the prescaled source as the root half-period strobe.
- R11: Writing all zeros to the prescaler word disables the prescaler at the next frame boundary.
- R12: In ST_MASTER chan_o equals lrclk_o (0 = left, 1 = right). In ST_HALT and ST_IDLE it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick_i | input | 1 | Peripheral-bus source tick strobe |
| aud_tick_i | input | 1 | Dedicated audio source tick strobe |
| root_in_tick_i | input | 1 | One strobe per half-period of an incoming root clock |
| bclk_i | input | 1 | External bit clock level (slave mode) |
| lrclk_i | input | 1 | External frame clock level (slave mode) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 = mode word, 1 = prescaler word |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| mclk_o | output | 1 | Root clock |
| mclk_oe_o | output | 1 | Root clock pin output enable |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| port_oe_o | output | 1 | Output enable for bit and frame clock pins |
| chan_o | output | 1 | Current channel flag |

## Verification
The bench targets writes that land in the middle of a frame. A design that loaded settings at once would change the bit-clock period or drop the frame clock mid-frame. It also covers prescaler writes that shrink the divide value below the running count. A design that did not clear the count at the boundary would stretch one root half-period for almost the full counter range. It covers illegal ratio pairs, which a careless divider would run with a truncated quotient instead of holding the clocks low. Last, it covers source and root-direction switches, which would show up as root edges timed by the wrong strobe. Unequal source patterns make each strobe distinguishable at the outputs.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2,
        ST_HALT   = 2'd3
    } acg_state_e;

    // Mode word layout, LSB first: source, slave, root-in, root code, bit code
    typedef struct packed {
        logic [1:0] bit_code;
        logic [1:0] root_code;
        logic       root_in;
        logic       slave;
        logic       src_aud;
    } acg_mode_t;

    localparam int unsigned MODE_W = $bits(acg_mode_t);

    function automatic int unsigned root_mult(input logic [1:0] code);
        unique case (code)
            2'd0:    return 256;
            2'd1:    return 384;
            2'd2:    return 512;
            default: return 768;
        endcase
    endfunction

    function automatic int unsigned bit_mult(input logic [1:0] code);
        unique case (code)
            2'd0:    return 16;
            2'd1:    return 24;
            2'd2:    return 32;
            default: return 48;
        endcase
    endfunction

endpackage

// File: rtl/acg_cfg_regs.sv
module acg_cfg_regs
    import acg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output acg_mode_t         mode_o,
    output logic              pre_en_o,
    output logic [DIV_W-1:0]  pre_div_o
);
    localparam int DIV_LSB = 8;

    logic unused_bits;
    assign unused_bits = ^{wdata_i[DATA_W-1:MODE_W], wdata_i[DIV_LSB-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o    <= '0;
            pre_en_o  <= 1'b0;
            pre_div_o <= '0;
        end else if (we_i) begin
            if (!addr_i) begin
                mode_o <= acg_mode_t'(wdata_i[MODE_W-1:0]);
            end else begin
                pre_en_o  <= wdata_i[0];
                pre_div_o <= wdata_i[DIV_LSB+DIV_W-1:DIV_LSB];
            end
        end
    end

endmodule

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             src_aud_i,
    input  logic             bus_tick_i,
    input  logic             aud_tick_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             src_tick;
    logic             at_end;

    assign src_tick = src_aud_i ? aud_tick_i : bus_tick_i;
    assign at_end   = (cnt_q == div_i);
    assign tick_o   = src_tick && (!en_i || at_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (src_tick && en_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/acg_divchain.sv
module acg_divchain #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             root_tick_i,
    input  logic [CNT_W-1:0] half_len_i,
    input  logic [CNT_W-1:0] bit_len_i,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             frame_end_o
);
    logic [CNT_W-1:0] rcnt_q;
    logic [CNT_W-1:0] bcnt_q;
    logic             r_last;
    logic             b_last;

    assign r_last      = (rcnt_q == half_len_i - CNT_W'(1));
    assign b_last      = (bcnt_q == bit_len_i - CNT_W'(1));
    assign frame_end_o = root_tick_i && r_last && b_last && lrclk_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt_q  <= '0;
            bcnt_q  <= '0;
            mclk_o  <= 1'b0;
            bclk_o  <= 1'b0;
            lrclk_o <= 1'b0;
        end else if (clr_i) begin
            rcnt_q  <= '0;
            bcnt_q  <= '0;
            mclk_o  <= 1'b0;
            bclk_o  <= 1'b0;
            lrclk_o <= 1'b0;
        end else if (root_tick_i) begin
            mclk_o <= ~mclk_o;
            if (r_last) begin
                rcnt_q <= '0;
                bclk_o <= ~bclk_o;
                if (b_last) begin
                    bcnt_q  <= '0;
                    lrclk_o <= ~lrclk_o;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end else begin
                rcnt_q <= rcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import acg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick_i,
    input  logic              aud_tick_i,
    input  logic              root_in_tick_i,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              cfg_we_i,
    input  logic              cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              mclk_o,
    output logic              mclk_oe_o,
    output logic              bclk_o,
    output logic              lrclk_o,
    output logic              port_oe_o,
    output logic              chan_o
);
    acg_state_e       state_q, state_d;

    acg_mode_t        sh_mode;
    logic             sh_pre_en;
    logic [DIV_W-1:0] sh_pre_div;

    acg_mode_t        act_mode;
    logic             act_pre_en;
    logic [DIV_W-1:0] act_pre_div;
    logic [CNT_W-1:0] act_half;
    logic [CNT_W-1:0] act_bits;

    int unsigned      sh_root;
    int unsigned      sh_bit;
    logic             sh_legal;
    logic             load;
    logic             running;

    logic             pre_tick;
    logic             root_tick;
    logic             ch_mclk, ch_bclk, ch_lr, frame_end;

    logic             bclk_in_q;
    logic             slave_chan_q;

    acg_cfg_regs #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .mode_o    (sh_mode),
        .pre_en_o  (sh_pre_en),
        .pre_div_o (sh_pre_div)
    );

    assign sh_root  = root_mult(sh_mode.root_code);
    assign sh_bit   = bit_mult(sh_mode.bit_code);
    assign sh_legal = ((sh_root % sh_bit) == 0);
    assign running  = (state_q == ST_MASTER);
    assign load     = !running || frame_end;

    // next-state decision, taken only on a load
    always_comb begin
        state_d = state_q;
        if (load) begin
            if (sh_mode.slave) begin
                state_d = ST_SLAVE;
            end else if (!sh_legal) begin
                state_d = ST_HALT;
            end else begin
                state_d = ST_MASTER;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // active settings follow the shadow on every load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mode    <= '0;
            act_pre_en  <= 1'b0;
            act_pre_div <= '0;
            act_half    <= CNT_W'(1);
            act_bits    <= CNT_W'(1);
        end else if (load) begin
            act_mode    <= sh_mode;
            act_pre_en  <= sh_pre_en;
            act_pre_div <= sh_pre_div;
            act_half    <= CNT_W'(sh_root / sh_bit);
            act_bits    <= CNT_W'(sh_bit);
        end
    end

    acg_prescaler #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (load),
        .src_aud_i  (act_mode.src_aud),
        .bus_tick_i (bus_tick_i),
        .aud_tick_i (aud_tick_i),
        .en_i       (act_pre_en),
        .div_i      (act_pre_div),
        .tick_o     (pre_tick)
    );

    assign root_tick = act_mode.root_in ? root_in_tick_i : pre_tick;

    acg_divchain #(
        .CNT_W (CNT_W)
    ) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!running),
        .root_tick_i (root_tick),
        .half_len_i  (act_half),
        .bit_len_i   (act_bits),
        .mclk_o      (ch_mclk),
        .bclk_o      (ch_bclk),
        .lrclk_o     (ch_lr),
        .frame_end_o (frame_end)
    );

    // slave-side channel tracker, sampled on rising external bit clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_in_q    <= 1'b0;
            slave_chan_q <= 1'b0;
        end else begin
            bclk_in_q <= bclk_i;
            if (bclk_i && !bclk_in_q) begin
                slave_chan_q <= lrclk_i;
            end
        end
    end

    // outputs per state
    always_comb begin
        mclk_o    = 1'b0;
        mclk_oe_o = 1'b0;
        bclk_o    = 1'b0;
        lrclk_o   = 1'b0;
        port_oe_o = 1'b0;
        chan_o    = 1'b0;
        unique case (state_q)
            ST_MASTER: begin
                mclk_o    = ch_mclk && !act_mode.root_in;
                mclk_oe_o = !act_mode.root_in;
                bclk_o    = ch_bclk;
                lrclk_o   = ch_lr;
                port_oe_o = 1'b1;
                chan_o    = ch_lr;
            end
            ST_HALT: begin
                mclk_oe_o = !act_mode.root_in;
                port_oe_o = 1'b1;
            end
            ST_SLAVE: begin
                chan_o = slave_chan_q;
            end
            default: begin
                chan_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acg_checker.sv
module acg_checker
    import acg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input acg_state_e state_q,
    input logic       ch_mclk,
    input logic       ch_bclk,
    input logic       mclk_o,
    input logic       mclk_oe_o,
    input logic       bclk_o,
    input logic       lrclk_o,
    input logic       port_oe_o,
    input logic       chan_o,
    input logic       bclk_i,
    input logic       lrclk_i
);

    AST_BCLK_ON_ROOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_bclk) |-> !$stable(ch_mclk)); // R4

    AST_LR_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe_o && !$stable(lrclk_o)) |-> $fell(bclk_o)); // R5

    AST_HALT_CHAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (!ch_mclk && !ch_bclk && !lrclk_o)); // R7

    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLAVE) |-> (!port_oe_o && !mclk_oe_o && !ch_bclk)); // R9

    AST_SLAVE_CHAN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLAVE && $past(state_q) == ST_SLAVE && !$stable(chan_o))
        |-> ($past(bclk_i) && !$past(bclk_i, 2) && chan_o == $past(lrclk_i))); // R9

    AST_MCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_oe_o |-> !mclk_o); // R10

endmodule

bind audio_clkgen acg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .ch_mclk   (ch_mclk),
    .ch_bclk   (ch_bclk),
    .mclk_o    (mclk_o),
    .mclk_oe_o (mclk_oe_o),
    .bclk_o    (bclk_o),
    .lrclk_o   (lrclk_o),
    .port_oe_o (port_oe_o),
    .chan_o    (chan_o),
    .bclk_i    (bclk_i),
    .lrclk_i   (lrclk_i)
);

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick_i = 1'b0;
    logic        aud_tick_i = 1'b0;
    logic        root_in_tick_i = 1'b0;
    logic        bclk_i = 1'b0;
    logic        lrclk_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_addr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        mclk_o, mclk_oe_o, bclk_o, lrclk_o, port_oe_o, chan_o;

    int    n_checks = 0;
    int    n_fail = 0;
    int    k = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // 4 ns period: 250 MHz
    always #2 clk = ~clk;

    audio_clkgen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_tick_i     (bus_tick_i),
        .aud_tick_i     (aud_tick_i),
        .root_in_tick_i (root_in_tick_i),
        .bclk_i         (bclk_i),
        .lrclk_i        (lrclk_i),
        .cfg_we_i       (cfg_we_i),
        .cfg_addr_i     (cfg_addr_i),
        .cfg_wdata_i    (cfg_wdata_i),
        .mclk_o         (mclk_o),
        .mclk_oe_o      (mclk_oe_o),
        .bclk_o         (bclk_o),
        .lrclk_o        (lrclk_o),
        .port_oe_o      (port_oe_o),
        .chan_o         (chan_o)
    );

    // ---------------- behavioural reference ----------------
    // mode: 0 idle, 1 master, 2 slave, 3 halt
    int m_mode = 0, m_t = 0, m_p = 0;
    int sh_src = 0, sh_slave = 0, sh_rin = 0, sh_rc = 0, sh_bc = 0, sh_pen = 0, sh_pdiv = 0;
    int a_src = 0, a_rin = 0, a_rc = 0, a_bc = 0, a_pen = 0, a_pdiv = 0;
    int m_bprev = 0, m_chs = 0;

    function automatic int rmul(int c);
        int tbl[4] = '{256, 384, 512, 768};
        return tbl[c];
    endfunction

    function automatic int bmul(int c);
        int tbl[4] = '{16, 24, 32, 48};
        return tbl[c];
    endfunction

    always @(posedge clk) begin
        bit src, tk, fe;
        if (!rst_n) begin
            m_mode = 0; m_t = 0; m_p = 0;
            sh_src = 0; sh_slave = 0; sh_rin = 0; sh_rc = 0; sh_bc = 0; sh_pen = 0; sh_pdiv = 0;
            a_src = 0; a_rin = 0; a_rc = 0; a_bc = 0; a_pen = 0; a_pdiv = 0;
            m_bprev = 0; m_chs = 0;
        end else begin
            fe = 1'b0;
            if (m_mode == 1) begin
                src = (a_src != 0) ? aud_tick_i : bus_tick_i;
                tk  = src && (a_pen == 0 || m_p == a_pdiv);
                if (src && a_pen != 0) m_p = (m_p == a_pdiv) ? 0 : m_p + 1;
                if (a_rin != 0) tk = root_in_tick_i;
                if (tk) begin
                    m_t++;
                    if (m_t == 2 * rmul(a_rc)) begin
                        m_t = 0;
                        fe = 1'b1;
                    end
                end
            end
            if (m_mode != 1 || fe) begin
                a_src = sh_src; a_rin = sh_rin; a_rc = sh_rc; a_bc = sh_bc;
                a_pen = sh_pen; a_pdiv = sh_pdiv;
                m_p = 0; m_t = 0;
                if (sh_slave != 0) m_mode = 2;
                else if (rmul(sh_rc) % bmul(sh_bc) != 0) m_mode = 3;
                else m_mode = 1;
            end
            if (bclk_i && m_bprev == 0) m_chs = int'(lrclk_i);
            m_bprev = int'(bclk_i);
            if (cfg_we_i) begin
                if (!cfg_addr_i) begin
                    sh_src   = int'(cfg_wdata_i[0]);
                    sh_slave = int'(cfg_wdata_i[1]);
                    sh_rin   = int'(cfg_wdata_i[2]);
                    sh_rc    = int'(cfg_wdata_i[4:3]);
                    sh_bc    = int'(cfg_wdata_i[6:5]);
                end else begin
                    sh_pen  = int'(cfg_wdata_i[0]);
                    sh_pdiv = int'(cfg_wdata_i[15:8]);
                end
            end
        end
    end

    task automatic check_outs();
        logic [5:0] exp_v, got_v;
        int h;
        exp_v = '0;
        if (m_mode == 1) begin
            h = rmul(a_rc) / bmul(a_bc);
            exp_v[5] = (m_t % 2 == 1) && (a_rin == 0);
            exp_v[4] = (a_rin == 0);
            exp_v[3] = ((m_t / h) % 2) == 1;
            exp_v[2] = ((m_t / rmul(a_rc)) % 2) == 1;
            exp_v[1] = 1'b1;
            exp_v[0] = exp_v[2];
        end else if (m_mode == 3) begin
            exp_v[4] = (a_rin == 0);
            exp_v[1] = 1'b1;
        end else if (m_mode == 2) begin
            exp_v[0] = (m_chs != 0);
        end
        got_v = {mclk_o, mclk_oe_o, bclk_o, lrclk_o, port_oe_o, chan_o};
        n_checks++;
        if (got_v !== exp_v) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL %s cycle %0d: got %b expected %b {mclk,mclk_oe,bclk,lr,oe,chan}",
                         cur_req, k, got_v, exp_v);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk);
            check_outs();
            k++;
            cfg_we_i       = 1'b0;
            bus_tick_i     = (k % 5) != 4;
            aud_tick_i     = (k % 2) == 0;
            root_in_tick_i = (k % 3) == 0;
            bclk_i         = ((k / 3) % 2) == 1;
            lrclk_i        = ((k / 17) % 2) == 1;
        end
    endtask

    task automatic wr(bit addr, logic [15:0] data);
        cfg_we_i    = 1'b1;
        cfg_addr_i  = addr;
        cfg_wdata_i = data;
        cyc(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        n_checks++;
        if ({mclk_o, mclk_oe_o, bclk_o, lrclk_o, port_oe_o, chan_o} !== 6'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got %b expected 000000",
                     {mclk_o, mclk_oe_o, bclk_o, lrclk_o, port_oe_o, chan_o});
        end
        rst_n = 1'b1;
        cyc(2);
        cur_req = "R4 R5 R12";
        cyc(1200);
        cur_req = "R8 R6";
        wr(1'b0, 16'h0028);           // root 384, bit 24, written mid-frame
        cyc(2000);
        cur_req = "R2";
        wr(1'b1, 16'h0201);           // prescaler on, value 2
        cyc(4000);
        cur_req = "R3 R6";
        wr(1'b0, 16'h0079);           // audio source, root 768, bit 48
        cyc(12000);
        cur_req = "R11";
        wr(1'b1, 16'h0000);
        cyc(10000);
        cur_req = "R7";
        wr(1'b0, 16'h0020);           // 256 with 24: illegal
        cyc(3500);
        cur_req = "R10 R6";
        wr(1'b0, 16'h0054);           // root in, root 512, bit 32
        cyc(6000);
        cur_req = "R9";
        wr(1'b0, 16'h0002);
        cyc(4000);
        cur_req = "R1 R4";
        wr(1'b0, 16'h0000);
        cyc(2000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule